// File: doc/BRIEF.md
# Dual-Channel Carrier Loop Player

This block replays a precomputed baseband carrier comb without a break. The in-phase (I) and quadrature (Q) parts sit in two independent on-chip memories. Each memory word is wide and packs four 36-bit slots, and every slot carries one 16-bit sample. A host port fills either memory while playback is off. Once `play_en` is raised, both memories are read at the same address. Each word is split across two consecutive fabric cycles, so each channel sends two samples per cycle to a converter that runs at twice the fabric rate.

The length of the loop sets the tone frequency resolution. For that reason the address counter wraps from the last address back to address 0 with no idle cycle and no repeated sample. The memory depth is a parameter, so a short loop can be used to exercise the wrap.

A three-state controller sequences playback:
- `ST_IDLE` accepts host writes and holds the outputs at zero.
- `ST_PRIME` waits one cycle while the first word is read from memory.
- `ST_STREAM` emits sample pairs.

The transitions are:
- *start*: `ST_IDLE` to `ST_PRIME` when `play_en` is sampled high.
- *fill*: `ST_PRIME` to `ST_STREAM` when `play_en` is still high.
- *halt*: any state to `ST_IDLE` when `play_en` is sampled low.

Top module: `carrier_loop_player`

## Requirements
- R1: While `rst_n` is low, `dac_valid` is 0 and both `dac_i` and `dac_q` are 0. After reset the block is in `ST_IDLE`.
- R2: A host write stores `host_wr_data` at `host_wr_addr`. `host_wr_sel` = 0 selects the I memory and 1 selects the Q memory. Slot k occupies bits [36k+35:36k]. Its sample is the slot's low 16 bits, and the upper 20 bits of each slot have no effect on the output.
- R3: A write takes effect only at an edge where `play_en` is low and was also low at the previous edge (or at the first edge after reset). Any other write leaves the stored waveform unchanged.
- R4: `dac_valid` rises at the second clock edge after the first edge that samples `play_en` high, provided `play_en` stays high at both edges. The first pair is slots 0 and 1 of address 0, with lane j at bits [16j+15:16j] of `dac_i` and `dac_q`. If `play_en` drops earlier, `dac_valid` never rises.
- R5: Each word is emitted over two consecutive cycles: slots 0 and 1 first, then slots 2 and 3. Addresses follow in ascending order.
- R6: After the last address the player returns to address 0. `dac_valid` stays high with no gap and no repeated pair for as long as `play_en` stays high.
- R7: `dac_i` and `dac_q` always carry the same address and slot indices.
- R8: At the edge where `play_en` is sampled low, `dac_valid` falls and the outputs go to 0. The next start begins again at address 0, slot 0.
- R9: Whenever `dac_valid` is 0, `dac_i` and `dac_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous active-low reset |
| play_en | input | 1 | Playback enable; its rising edge restarts the loop |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_sel | input | 1 | Memory select: 0 = I, 1 = Q |
| host_wr_addr | input | ADDR_W | Word address of the write |
| host_wr_data | input | SLOTS*SLOT_W | Packed four-slot word |
| dac_i | output | LANES*SAMP_W | I sample pair, lane 0 in the low bits |
| dac_q | output | LANES*SAMP_W | Q sample pair, lane 0 in the low bits |
| dac_valid | output | 1 | Sample pair on the outputs is valid |

## Verification
The assertions take for granted the following about the inputs:
- `play_en` is held low during reset, so the first `$rose` after reset is a genuine start.
- `play_en` changes only between clock edges.
- The host drives `host_wr_sel` and the address to known values whenever it strobes a write.

The stimulus drives every input on the falling edge and keeps `play_en` low throughout reset. It loads every address of both memories before any start. It then deliberately strobes writes while playing and on the halt edge itself, and also aborts a start during the priming cycle, all within those limits.

// File: rtl/clp_pkg.sv
package clp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRIME  = 2'd1,
        ST_STREAM = 2'd2
    } play_state_t;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/clp_ctrl.sv
module clp_ctrl
    import clp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PHASES = 2,
    parameter int PH_W   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              play_en,
    input  logic              host_wr_en,
    output logic              wr_ok,
    output logic              emit,
    output logic [PH_W-1:0]   phase,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);
    localparam logic [PH_W-1:0] PH_ADV  = PH_W'(PHASES - 2);

    play_state_t       state_q, state_d;
    logic [PH_W-1:0]   phase_q;
    logic [ADDR_W-1:0] addr_q;
    logic              adv;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start, fill, halt
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (play_en) state_d = ST_PRIME;
            ST_PRIME:  state_d = play_en ? ST_STREAM : ST_IDLE;
            ST_STREAM: if (!play_en) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        emit  = (state_q == ST_STREAM) && play_en;
        wr_ok = (state_q == ST_IDLE) && !play_en && host_wr_en;
        adv   = emit && (phase_q == PH_ADV);
    end

    // phase and address counters
    always_ff @(posedge clk) begin
        if (!rst_n || !emit) begin
            phase_q <= '0;
            addr_q  <= '0;
        end else begin
            phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
            if (adv) addr_q <= addr_q + 1'b1;
        end
    end

    assign phase   = phase_q;
    assign rd_addr = addr_q;

endmodule

// File: rtl/clp_wave_mem.sv
module clp_wave_mem #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 144
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        rdata <= store[raddr];
    end

endmodule

// File: rtl/clp_unpack.sv
module clp_unpack #(
    parameter int SLOTS  = 4,
    parameter int SLOT_W = 36,
    parameter int SAMP_W = 16,
    parameter int LANES  = 2,
    parameter int PH_W   = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     emit,
    input  logic [PH_W-1:0]          phase,
    input  logic [SLOTS*SLOT_W-1:0]  word_i,
    input  logic [SLOTS*SLOT_W-1:0]  word_q,
    output logic [LANES*SAMP_W-1:0]  out_i,
    output logic [LANES*SAMP_W-1:0]  out_q,
    output logic                     out_valid
);

    logic [LANES*SAMP_W-1:0] nxt_i, nxt_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            nxt_i[l*SAMP_W +: SAMP_W] = word_i[(int'(phase) * LANES + l) * SLOT_W +: SAMP_W];
            nxt_q[l*SAMP_W +: SAMP_W] = word_q[(int'(phase) * LANES + l) * SLOT_W +: SAMP_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !emit) begin
            out_i     <= '0;
            out_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_i     <= nxt_i;
            out_q     <= nxt_q;
            out_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/carrier_loop_player.sv
module carrier_loop_player
    import clp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SLOTS  = 4,
    parameter int SLOT_W = 36,
    parameter int SAMP_W = 16,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      play_en,
    input  logic                      host_wr_en,
    input  logic                      host_wr_sel,
    input  logic [ADDR_W-1:0]         host_wr_addr,
    input  logic [SLOTS*SLOT_W-1:0]   host_wr_data,
    output logic [LANES*SAMP_W-1:0]   dac_i,
    output logic [LANES*SAMP_W-1:0]   dac_q,
    output logic                      dac_valid
);

    localparam int WORD_W = SLOTS * SLOT_W;
    localparam int PHASES = SLOTS / LANES;
    localparam int PH_W   = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam int OUT_W  = LANES * SAMP_W;

    logic              wr_ok;
    logic              emit;
    logic [PH_W-1:0]   phase;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_word [NUM_CH];

    clp_ctrl #(
        .ADDR_W (ADDR_W),
        .PHASES (PHASES),
        .PH_W   (PH_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .play_en    (play_en),
        .host_wr_en (host_wr_en),
        .wr_ok      (wr_ok),
        .emit       (emit),
        .phase      (phase),
        .rd_addr    (rd_addr)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        clp_wave_mem #(
            .ADDR_W (ADDR_W),
            .WORD_W (WORD_W)
        ) u_mem (
            .clk   (clk),
            .we    (wr_ok && (host_wr_sel == 1'(ch))),
            .waddr (host_wr_addr),
            .wdata (host_wr_data),
            .raddr (rd_addr),
            .rdata (rd_word[ch])
        );
    end

    clp_unpack #(
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W),
        .SAMP_W (SAMP_W),
        .LANES  (LANES),
        .PH_W   (PH_W)
    ) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .emit      (emit),
        .phase     (phase),
        .word_i    (rd_word[0]),
        .word_q    (rd_word[1]),
        .out_i     (dac_i),
        .out_q     (dac_q),
        .out_valid (dac_valid)
    );

endmodule

// File: rtl/clp_checker.sv
module clp_checker #(
    parameter int ADDR_W = 8,
    parameter int OUT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              play_en,
    input logic              dac_valid,
    input logic [OUT_W-1:0]  dac_i,
    input logic [OUT_W-1:0]  dac_q,
    input logic              wr_ok,
    input logic [ADDR_W-1:0] rd_addr
);

    // R4: valid follows two edges after a sustained start
    p_start_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(play_en) ##1 play_en ##1 play_en) |=> dac_valid);

    // R4: nothing valid during the start and priming edges
    p_no_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(play_en) |=> (!dac_valid ##1 !dac_valid));

    // R8: halting drops valid and clears outputs at once
    p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !play_en |=> (!dac_valid && dac_i == '0 && dac_q == '0));

    // R9: outputs are zero whenever not valid
    p_zero_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_valid |-> (dac_i == '0 && dac_q == '0));

    // R3: memory writes happen only with playback off on two edges
    p_write_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |-> (!play_en && !$past(play_en)));

    // R6: streaming never drops out while enabled
    p_no_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_valid && play_en) |=> dac_valid);

    // R6: the read address holds or steps by one, wrapping
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dac_valid) && dac_valid) |->
            (rd_addr == $past(rd_addr) || rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

endmodule

bind carrier_loop_player clp_checker #(
    .ADDR_W (ADDR_W),
    .OUT_W  (OUT_W)
) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .play_en   (play_en),
    .dac_valid (dac_valid),
    .dac_i     (dac_i),
    .dac_q     (dac_q),
    .wr_ok     (wr_ok),
    .rd_addr   (rd_addr)
);

// File: tb/carrier_loop_player_test.sv
`timescale 1ns/1ps
module carrier_loop_player_test;

    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          play_en = 1'b0;
    logic          host_wr_en = 1'b0;
    logic          host_wr_sel = 1'b0;
    logic [AW-1:0] host_wr_addr = '0;
    logic [143:0]  host_wr_data = '0;
    logic [31:0]   dac_i, dac_q;
    logic          dac_valid;

    always #2 clk = ~clk;

    carrier_loop_player #(.ADDR_W(AW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .play_en      (play_en),
        .host_wr_en   (host_wr_en),
        .host_wr_sel  (host_wr_sel),
        .host_wr_addr (host_wr_addr),
        .host_wr_data (host_wr_data),
        .dac_i        (dac_i),
        .dac_q        (dac_q),
        .dac_valid    (dac_valid)
    );

    int    n_chk = 0, n_fail = 0, cycles = 0;
    bit    checking = 1'b0;
    string tag = "R1";

    // behavioural reference
    logic [15:0] ref_mem [2][DEPTH][4];
    int          run = 0;
    bit          prev_pe = 1'b0;
    bit          exp_v = 1'b0;
    logic [31:0] exp_i = '0, exp_q = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            run = 0;
            prev_pe = 1'b0;
        end else begin
            if (host_wr_en && !play_en && !prev_pe)
                for (int s = 0; s < 4; s++)
                    ref_mem[host_wr_sel][host_wr_addr][s] = host_wr_data[s*36 +: 16];
            run = play_en ? run + 1 : 0;
            prev_pe = play_en;
        end
        exp_v = (run >= 3);
        if (exp_v) begin
            int k, a, h;
            k = run - 3;
            a = (k / 2) % DEPTH;
            h = k % 2;
            exp_i = {ref_mem[0][a][2*h+1], ref_mem[0][a][2*h]};
            exp_q = {ref_mem[1][a][2*h+1], ref_mem[1][a][2*h]};
        end else begin
            exp_i = '0;
            exp_q = '0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(negedge clk) begin
        if (checking) begin
            chk(dac_valid === exp_v, tag, "dac_valid", 64'(dac_valid), 64'(exp_v));
            chk(dac_i === exp_i, tag, "dac_i", 64'(dac_i), 64'(exp_i));
            chk(dac_q === exp_q, exp_v ? "R7" : tag, "dac_q", 64'(dac_q), 64'(exp_q));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            finish_run();
        end
    end

    function automatic logic [143:0] make_word(input int ch, input int a, input bit alt);
        logic [143:0] w;
        for (int s = 0; s < 4; s++) begin
            logic [15:0] smp;
            if (alt)       smp = 16'hD000 + 16'(a * 4 + s);
            else if (ch == 0) smp = 16'h1000 + 16'(a * 4 + s);
            else           smp = 16'hA000 ^ 16'((a * 4 + s) * 3);
            w[s*36 +: 36] = {20'hF5A5A ^ 20'(a + s), smp};
        end
        return w;
    endfunction

    task automatic host_write(input int ch, input int a, input bit alt);
        host_wr_en   = 1'b1;
        host_wr_sel  = 1'(ch);
        host_wr_addr = AW'(a);
        host_wr_data = make_word(ch, a, alt);
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        @(posedge clk);
        @(negedge clk);
        checking = 1'b1;
        idle(4);
        rst_n = 1'b1;

        // R2: load both memories with distinct patterns, noisy upper slot bits
        tag = "R2";
        for (int a = 0; a < DEPTH; a++) begin
            host_write(0, a, 1'b0);
            host_write(1, a, 1'b0);
        end

        // R4: start latency and first pair; R5 ordering; R6 wrap
        tag = "R4";
        play_en = 1'b1;
        idle(5);
        tag = "R5";
        idle(12);
        tag = "R6";
        idle(40);

        // R3: writes while playing are ignored
        tag = "R3";
        host_write(0, 3, 1'b1);
        host_write(1, 3, 1'b1);
        idle(40);

        // R8 and R3: a write on the halt edge is also ignored
        tag = "R8";
        play_en = 1'b0;
        host_write(0, 7, 1'b1);
        tag = "R9";
        idle(3);

        // R2: an idle write is accepted
        tag = "R2";
        host_write(0, 5, 1'b1);
        host_write(1, 5, 1'b1);

        // R4: start aborted during priming never raises valid
        tag = "R4";
        play_en = 1'b1;
        idle(1);
        play_en = 1'b0;
        tag = "R9";
        idle(4);

        // R8: restart from address 0 slot 0, including updated word 5
        tag = "R8";
        play_en = 1'b1;
        idle(45);
        play_en = 1'b0;
        tag = "R9";
        idle(4);

        finish_run();
    end

endmodule